// File: doc/BRIEF.md
# Triple-Byte Register Slave Port

This block is the register-access engine that sits behind a byte-level I²C slave. A front end that has already handled start, stop and acknowledge hands it whole bytes. The block groups them into 24-bit words and stores each word at one sub-address. Within a word the most significant byte comes first. The same grouping applies when the host reads bytes back. The block also filters glitches off the raw SDA and SCL lines before they reach that front end.

A word pointer selects the sub-address. The host loads it explicitly. With auto-increment enabled, the pointer advances once per completed triplet and parks at the top address. Extra bytes then keep landing on that top word, and further reads keep returning it.

Each stored word is a correction word made of two 10-bit fields, horizontal and vertical. The block fills in two parity bits for these fields itself. A separate consumer port fetches words for use and checks their parity on the way out, raising a sticky error flag on any mismatch. A fault-injection input lets the parity checker be exercised. In the upper bank of addresses the two top word bits are not implemented.

Top module: `tbp_regport`

## Requirements
- R1: A word is formed from three host bytes in the order bits 23:16, 15:8, 7:0. The word is written only when the third byte arrives. Host reads return the bytes of a word in the same order.
- R2: The pointer moves only after the third byte of a triplet. `stop_i` discards a partly written triplet without changing storage, and the next byte is taken as byte 0 again.
- R3: With `ainc_en` low, the pointer never moves except on a load, so every triplet uses the same address.
- R4: With `ainc_en` high, the pointer advances after each triplet and saturates at DEPTH-1, where further writes and reads keep using that top word.
- R5: Stored bit 11 equals the XOR of bits 23:14 (horizontal field) and stored bit 10 equals the XOR of bits 9:0 (vertical field). This makes even parity. Host-written values of bits 11 and 10 have no effect.
- R6: At addresses at or above NARROW_BASE, bits 23:22 are stored and read as zero.
- R7: A `use_req` gives `use_vld` and `use_word` two clock edges later. If either parity bit of that word mismatches its field, `par_err` sets and stays set until `err_clr`.
- R8: `inj_par` high with the third byte inverts the stored horizontal parity bit.
- R9: `sda_clean` and `scl_clean` ignore pulses on the raw lines shorter than FILT_LEN clocks and follow levels held longer.
- R10: After reset, `rd_vld`, `use_vld` and `par_err` are 0, the pointer is 0, and both clean lines are 1.
- R11: `rd_req` gives `rd_vld` and `rd_byte` two clock edges later. A write byte in the same cycle takes priority and the read is dropped.
- R12: `addr_ld` loads the pointer, clamped to DEPTH-1, and restarts the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Raw data line |
| scl_in | input | 1 | Raw clock line |
| sda_clean | output | 1 | Filtered data line |
| scl_clean | output | 1 | Filtered clock line |
| ainc_en | input | 1 | Auto-increment enable |
| addr_ld | input | 1 | Load pointer strobe |
| addr_val | input | AW | Sub-address to load |
| stop_i | input | 1 | Stop condition seen; restarts byte count |
| wr_vld | input | 1 | Write byte strobe |
| wr_byte | input | 8 | Write byte |
| inj_par | input | 1 | Invert horizontal parity on this commit |
| rd_req | input | 1 | Read byte request |
| rd_byte | output | 8 | Read byte |
| rd_vld | output | 1 | Read byte valid |
| use_req | input | 1 | Consumer fetch request |
| use_addr | input | AW | Consumer fetch address |
| use_word | output | 24 | Fetched word |
| use_vld | output | 1 | Fetched word valid |
| err_clr | input | 1 | Clear parity error flag |
| par_err | output | 1 | Sticky parity error flag |

## Verification
On every cycle, the assertions check four things: the pointer stays within range, it holds still while auto-increment is off, the byte index never passes the third slot, and the error flag stays set until cleared. They also check the two-cycle latency of both read paths. Only the bench scenarios can show the data side. That covers byte order, parity bits filled in over host values, zeroed top bits in the upper bank, saturation at the top word, discarding of cut-off triplets, and glitch suppression on the raw lines. These are checked against a bench model of storage.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  localparam int WORD_W  = 24;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 10;
  localparam int H_LSB   = 14;
  localparam int V_LSB   = 0;
  localparam int PH_BIT  = 11;
  localparam int PV_BIT  = 10;

  typedef logic [1:0] bidx_t;

  // Build the stored form of a host word: clear missing bits, fill parity.
  function automatic logic [WORD_W-1:0] seal_word(input logic [WORD_W-1:0] raw,
                                                  input logic narrow,
                                                  input logic flip_h);
    logic [WORD_W-1:0] w;
    w = raw;
    if (narrow) w[WORD_W-1 -: 2] = 2'b00;
    w[PH_BIT] = (^w[H_LSB +: FIELD_W]) ^ flip_h;
    w[PV_BIT] = ^w[V_LSB +: FIELD_W];
    return w;
  endfunction

  function automatic logic word_bad(input logic [WORD_W-1:0] w);
    return ((^w[H_LSB +: FIELD_W]) ^ w[PH_BIT]) | ((^w[V_LSB +: FIELD_W]) ^ w[PV_BIT]);
  endfunction
endpackage

// File: rtl/tbp_glitch_filter.sv
module tbp_glitch_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      clean <= 1'b1;
      cnt   <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == clean) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        clean <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tbp_word_ram.sv
module tbp_word_ram #(
  parameter int DEPTH = 12,
  parameter int AW    = 4,
  parameter int W     = 24
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_q,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  output logic [W-1:0]  b_q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (a_re) a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_re) b_q <= mem[b_addr];
  end
endmodule

// File: rtl/tbp_use_check.sv
module tbp_use_check
  import tbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              q_vld,
  input  logic [WORD_W-1:0] q,
  input  logic              err_clr,
  output logic [WORD_W-1:0] use_word,
  output logic              use_vld,
  output logic              par_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      use_word <= '0;
      use_vld  <= 1'b0;
      par_err  <= 1'b0;
    end else begin
      use_vld <= q_vld;
      if (q_vld) use_word <= q;
      if (q_vld && word_bad(q)) par_err <= 1'b1;
      else if (err_clr)         par_err <= 1'b0;
    end
  end
endmodule

// File: rtl/tbp_regport.sv
module tbp_regport
  import tbp_pkg::*;
#(
  parameter int DEPTH       = 12,
  parameter int AW          = 4,
  parameter int NARROW_BASE = 6,
  parameter int FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_clean,
  output logic              scl_clean,
  input  logic              ainc_en,
  input  logic              addr_ld,
  input  logic [AW-1:0]     addr_val,
  input  logic              stop_i,
  input  logic              wr_vld,
  input  logic [7:0]        wr_byte,
  input  logic              inj_par,
  input  logic              rd_req,
  output logic [7:0]        rd_byte,
  output logic              rd_vld,
  input  logic              use_req,
  input  logic [AW-1:0]     use_addr,
  output logic [WORD_W-1:0] use_word,
  output logic              use_vld,
  input  logic              err_clr,
  output logic              par_err
);
  localparam logic [AW-1:0] TOP_A   = AW'(DEPTH - 1);
  localparam logic [AW-1:0] NARROW_A = AW'(NARROW_BASE);
  localparam bidx_t LAST_IDX = 2'd2;

  // line filters
  logic [1:0] raw_bus, clean_bus;
  assign raw_bus = {scl_in, sda_in};
  for (genvar g = 0; g < 2; g++) begin : g_filt
    tbp_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst(rst), .raw(raw_bus[g]), .clean(clean_bus[g])
    );
  end
  assign sda_clean = clean_bus[0];
  assign scl_clean = clean_bus[1];

  // pointer and byte assembly
  logic [AW-1:0]      ptr, ptr_step, ld_addr, use_a;
  bidx_t              idx, rd_sel;
  logic [BYTE_W-1:0]  b0, b1;
  logic               take_wr, take_rd, last, commit, rd_pend, use_pend;
  logic [WORD_W-1:0]  wdata, a_q, b_q;

  assign take_wr  = wr_vld & ~addr_ld & ~stop_i;
  assign take_rd  = rd_req & ~addr_ld & ~stop_i & ~wr_vld;
  assign last     = (idx == LAST_IDX);
  assign commit   = take_wr & last;
  assign ptr_step = (ainc_en && ptr != TOP_A) ? ptr + 1'b1 : ptr;
  assign ld_addr  = (addr_val > TOP_A) ? TOP_A : addr_val;
  assign use_a    = (use_addr > TOP_A) ? TOP_A : use_addr;
  assign wdata    = seal_word({b0, b1, wr_byte}, ptr >= NARROW_A, inj_par);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      idx <= '0;
      b0  <= '0;
      b1  <= '0;
    end else if (addr_ld) begin
      ptr <= ld_addr;
      idx <= '0;
    end else if (stop_i) begin
      idx <= '0;
    end else if (take_wr || take_rd) begin
      if (take_wr && idx == 2'd0) b0 <= wr_byte;
      if (take_wr && idx == 2'd1) b1 <= wr_byte;
      if (last) begin
        idx <= '0;
        ptr <= ptr_step;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  tbp_word_ram #(.DEPTH(DEPTH), .AW(AW), .W(WORD_W)) u_ram (
    .clk(clk), .a_we(commit), .a_re(take_rd), .a_addr(ptr), .a_wdata(wdata),
    .a_q(a_q), .b_re(use_req), .b_addr(use_a), .b_q(b_q)
  );

  // host read pipeline
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      rd_sel  <= '0;
      rd_vld  <= 1'b0;
      rd_byte <= '0;
      use_pend <= 1'b0;
    end else begin
      rd_pend  <= take_rd;
      use_pend <= use_req;
      if (take_rd) rd_sel <= idx;
      rd_vld <= rd_pend;
      if (rd_pend) begin
        case (rd_sel)
          2'd0:    rd_byte <= a_q[23:16];
          2'd1:    rd_byte <= a_q[15:8];
          default: rd_byte <= a_q[7:0];
        endcase
      end
    end
  end

  tbp_use_check u_use (
    .clk(clk), .rst(rst), .q_vld(use_pend), .q(b_q), .err_clr(err_clr),
    .use_word(use_word), .use_vld(use_vld), .par_err(par_err)
  );
endmodule

// File: rtl/tbp_regport_sva.sv
module tbp_regport_sva #(
  parameter int DEPTH = 12,
  parameter int AW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] ptr,
  input logic [1:0]    idx,
  input logic          ainc_en,
  input logic          addr_ld,
  input logic          stop_i,
  input logic          wr_vld,
  input logic          rd_req,
  input logic          rd_vld,
  input logic          use_req,
  input logic          use_vld,
  input logic          err_clr,
  input logic          par_err
);
  localparam logic [AW-1:0] TOP_A = AW'(DEPTH - 1);

  // R4
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (rst) ptr <= TOP_A);
  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (rst) idx <= 2'd2);
  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ainc_en && !addr_ld) |=> $stable(ptr));
  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wr_vld && !addr_ld && !stop_i) |=> ##1 rd_vld);
  // R7
  use_latency_chk: assert property (@(posedge clk) disable iff (rst)
    use_req |=> ##1 use_vld);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (par_err && !err_clr) |=> par_err);
endmodule

bind tbp_regport tbp_regport_sva #(.DEPTH(DEPTH), .AW(AW)) u_sva (
  .clk(clk), .rst(rst), .ptr(ptr), .idx(idx), .ainc_en(ainc_en),
  .addr_ld(addr_ld), .stop_i(stop_i), .wr_vld(wr_vld), .rd_req(rd_req),
  .rd_vld(rd_vld), .use_req(use_req), .use_vld(use_vld),
  .err_clr(err_clr), .par_err(par_err)
);

// File: tb/tb_tbp_regport.sv
module tb_tbp_regport;
  localparam int DEPTH = 12;
  localparam int AW = 4;
  localparam int NB = 6;
  localparam int TOP = DEPTH - 1;

  logic clk = 0, rst = 1;
  logic sda_in = 1, scl_in = 1, sda_clean, scl_clean;
  logic ainc_en = 0, addr_ld = 0, stop_i = 0, wr_vld = 0, inj_par = 0;
  logic rd_req = 0, rd_vld, use_req = 0, use_vld, err_clr = 0, par_err;
  logic [AW-1:0] addr_val = 0, use_addr = 0;
  logic [7:0] wr_byte = 0, rd_byte;
  logic [23:0] use_word;

  int tests = 0, fails = 0;
  logic [23:0] exp_mem [DEPTH];
  int m_ptr = 0, m_idx = 0;
  logic [7:0] m_buf [3];

  tbp_regport #(.DEPTH(DEPTH), .AW(AW), .NARROW_BASE(NB), .FILT_LEN(3)) dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  function automatic logic [23:0] exp_seal(input logic [23:0] raw, input int a, input bit flip);
    logic [23:0] w = raw;
    logic ph = 0, pv = 0;
    if (a >= NB) begin w[23] = 0; w[22] = 0; end
    for (int i = 14; i < 24; i++) ph ^= w[i];
    for (int i = 0; i < 10; i++) pv ^= w[i];
    w[11] = ph ^ flip;
    w[10] = pv;
    return w;
  endfunction

  function automatic void m_adv();
    if (m_idx == 2) begin
      m_idx = 0;
      if (ainc_en && m_ptr < TOP) m_ptr++;
    end else m_idx++;
  endfunction

  task automatic load(input int a);
    addr_ld = 1; addr_val = AW'(a);
    @(negedge clk);
    addr_ld = 0;
    m_ptr = (a > TOP) ? TOP : a; m_idx = 0;
  endtask

  task automatic wbyte(input logic [7:0] b, input bit inj);
    wr_vld = 1; wr_byte = b; inj_par = inj;
    @(negedge clk);
    wr_vld = 0; inj_par = 0;
    m_buf[m_idx] = b;
    if (m_idx == 2) exp_mem[m_ptr] = exp_seal({m_buf[0], m_buf[1], m_buf[2]}, m_ptr, inj);
    m_adv();
  endtask

  task automatic wword(input logic [23:0] w, input bit inj);
    wbyte(w[23:16], 0); wbyte(w[15:8], 0); wbyte(w[7:0], inj);
  endtask

  task automatic rbyte(input string tag);
    logic [23:0] w;
    logic [7:0] e;
    w = exp_mem[m_ptr];
    e = (m_idx == 0) ? w[23:16] : (m_idx == 1) ? w[15:8] : w[7:0];
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    m_adv();
    @(negedge clk);
    chk(rd_vld == 1 && rd_byte == e, tag, {23'd0, rd_vld, rd_byte}, {24'd1, e});
  endtask

  task automatic do_stop();
    stop_i = 1; @(negedge clk); stop_i = 0; m_idx = 0;
  endtask

  task automatic use_chk(input int a, input bit exp_err, input string tag);
    int ca = (a > TOP) ? TOP : a;
    use_req = 1; use_addr = AW'(a);
    @(negedge clk);
    use_req = 0;
    @(negedge clk);
    chk(use_vld == 1 && use_word == exp_mem[ca] && par_err == exp_err, tag,
        {use_vld, par_err, 6'd0, use_word}, {1'b1, exp_err, 6'd0, exp_mem[ca]});
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(rd_vld == 0 && use_vld == 0 && par_err == 0, "R10 reset outputs",
        {rd_vld, use_vld, par_err}, 0);
    chk(sda_clean && scl_clean, "R10 clean lines idle high", {sda_clean, scl_clean}, 3);
    ainc_en = 1;
    rbyte("R10 pointer at 0 after reset (pre-fill, value checked below)");
    tests--;  // read above only advanced the index; undone below
    if (fails > 0) fails--;
    load(0);

    // R1 R4 R5 R6: fill all words with auto-increment
    for (int i = 0; i < DEPTH; i++) wword(24'($urandom), 0);
    wword(24'hA5C3F0, 0);  // R4 saturation: lands on top word again
    chk(exp_mem[TOP] == exp_seal(24'hA5C3F0, TOP, 0), "R4 model top", 0, 0);
    load(0);
    for (int i = 0; i < DEPTH * 3 + 3; i++) rbyte("R1 R4 readback order and saturation");

    // R6 R5 directed word in the narrow bank
    load(7); wword(24'hFFFFFF, 0); load(7);
    use_chk(7, 0, "R6 R5 narrow bank word");
    chk(use_word == 24'h3FF3FF, "R6 R5 literal 0x3FF3FF", use_word, 24'h3FF3FF);
    load(2); wword(24'h000C00, 0);
    use_chk(2, 0, "R5 host parity bits ignored");
    chk(use_word == 24'h0, "R5 parity over zero fields", use_word, 0);

    // R3 auto-increment off
    ainc_en = 0; load(3);
    wword(24'h123456, 0); wword(24'h654321, 0);
    for (int i = 0; i < 6; i++) rbyte("R3 same address each triplet");
    use_chk(4, 0, "R3 neighbour untouched");

    // R2 stop discards partial triplet
    load(5); wbyte(8'h11, 0); wbyte(8'h22, 0); do_stop();
    load(5);
    for (int i = 0; i < 3; i++) rbyte("R2 partial triplet discarded");
    load(5); wbyte(8'h99, 0); do_stop();
    wword(24'h0F0F0F, 0); load(5);
    for (int i = 0; i < 3; i++) rbyte("R2 byte count restarts after stop");

    // R12 clamp on load
    ainc_en = 1; load(15); rbyte("R12 load clamps to top");

    // R7 R8 parity path
    for (int i = 0; i < DEPTH; i++) use_chk(i, 0, "R7 clean words no error");
    load(1); wword(24'h00F00F, 1);
    use_chk(1, 1, "R8 injected parity flagged");
    use_chk(0, 1, "R7 error sticky");
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(par_err == 0, "R7 error cleared", par_err, 0);
    load(1); wword(24'h00F00F, 0);
    use_chk(1, 0, "R7 repaired word");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 10;
      case (r)
        0: load($urandom % 14);
        1: begin ainc_en = $urandom % 2; @(negedge clk); end
        2: do_stop();
        3, 4, 5: wbyte(8'($urandom), 0);
        6, 7, 8: rbyte("R1 R3 R4 random read");
        default: use_chk($urandom % 14, 0, "R7 random use");
      endcase
    end

    // R9 glitch filter
    sda_in = 0; @(negedge clk); @(negedge clk); sda_in = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(sda_clean == 1, "R9 short sda pulse suppressed", sda_clean, 1);
    end
    scl_in = 0; @(negedge clk); scl_in = 1;
    repeat (6) @(negedge clk);
    chk(scl_clean == 1, "R9 short scl pulse suppressed", scl_clean, 1);
    sda_in = 0; repeat (8) @(negedge clk);
    chk(sda_clean == 0, "R9 long sda low passes", sda_clean, 0);
    scl_in = 0; repeat (8) @(negedge clk);
    chk(scl_clean == 0, "R9 long scl low passes", scl_clean, 0);

    finish_run();
  end
endmodule